// File: doc/BRIEF.md
# Double-Data-Rate Input Capture

This block samples one or more source-synchronous data pins on both edges of a capture clock and hands each pair of samples to logic in a single rising-edge domain. Each lane has three capture flops. The first takes the bit present at the rising edge. The second takes the bit present at the falling edge. The third re-times the falling-edge sample onto the rising-edge clock. A fourth flop holds the rising-edge sample back by one period, so both bits of a pair leave the block together on the same edge.

The falling-edge flop can be clocked in one of two ways. It can use the falling edge of the capture clock itself, or it can use the rising edge of a separate complementary strobe. A control input inverts the capture clock and the complementary strobe before they reach any flop, which memory interfaces with inverted strobe conventions need. A bypass input skips the capture flops and passes the raw pin straight to the output. A valid flag goes high once the capture path has seen its first clock after reset.

Top module: `ddr_in_capture`

## Requirements
- R1: Output bit 2k carries the value of pin d_i[k] sampled at an effective rising edge of the capture clock.
- R2: Output bit 2k+1 carries the value of d_i[k] sampled at the effective falling edge that follows that rising edge, so both bits of a pair come from the same clock period.
- R3: A pair whose rising sample is taken at effective rising edge n appears on data_o just after rising edge n+1. Both bits change together, and only on effective rising edges.
- R4: With sep_strobe_i = 0, both edges come from clk_i, and strobe_n_i has no effect on data_o.
- R5: With sep_strobe_i = 1, the falling-edge sample is taken at the effective rising edge of strobe_n_i. If that strobe is held still, the odd output bits keep their last value (0 after reset).
- R6: With invert_i = 1, clk_i and strobe_n_i are inverted before use, so the effective rising edge is a falling transition of clk_i.
- R7: With bypass_i = 1, data_o[2k] equals d_i[k] with no register in the path, and data_o[2k+1] is 0.
- R8: rst_n_i low asynchronously clears every capture flop and valid_o to 0.
- R9: valid_o stays 0 until the first effective rising edge after rst_n_i goes high, rises on that edge, and then stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock or strobe |
| strobe_n_i | input | 1 | Complementary strobe for the falling-edge sample |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sep_strobe_i | input | 1 | 1: falling sample is clocked by strobe_n_i; 0: by the falling edge of clk_i |
| invert_i | input | 1 | 1: invert clk_i and strobe_n_i before use |
| bypass_i | input | 1 | 1: pass the raw pins to the even output bits |
| d_i | input | LANES | Serial data pins |
| data_o | output | 2*LANES | Pairs: bit 2k is the rising sample, bit 2k+1 the falling sample |
| valid_o | output | 1 | Capture path has started after reset |

## Verification
The bench streams distinct rise/fall bit pairs and checks that each pair comes out one period later with its bits in the right places. A design that swapped the two bits, or that left out the alignment flop, would present bit pairs from neighbouring periods. The streams run in all four combinations of strobe mode and inversion. If inversion were ignored, every pair would shift by half a period, and the rise and fall bits would trade places.

Holding the complementary strobe still separates the two modes. In separate-strobe mode the odd bits must freeze at 0. In single-clock mode they must keep tracking the data. A design that chose the wrong clock would fail one of these two cases. Bypass, asynchronous reset in mid-stream, and the timing of valid are also checked.

// File: rtl/ddr_in_pkg.sv
package ddr_in_pkg;
   // One captured bit pair, rising sample in the low bit.
   typedef struct packed {
      logic fall;
      logic rise;
   } ddr_pair_t;

   localparam ddr_pair_t PAIR_ZERO = '{fall: 1'b0, rise: 1'b0};
endpackage

// File: rtl/ddr_clk_sel.sv
module ddr_clk_sel #(
   parameter bit SEP_STROBE_EN = 1'b1
) (
   input  logic clk_i,
   input  logic strobe_n_i,
   input  logic sep_strobe_i,
   input  logic invert_i,
   output logic rise_clk_o,
   output logic fall_clk_o
);
   logic clk_eff;
   assign clk_eff    = clk_i ^ invert_i;
   assign rise_clk_o = clk_eff;

   generate
      if (SEP_STROBE_EN) begin : g_sep
         logic strobe_eff;
         assign strobe_eff = strobe_n_i ^ invert_i;
         // A rising edge of fall_clk_o marks the falling-edge sample point.
         assign fall_clk_o = sep_strobe_i ? strobe_eff : ~clk_eff;
      end else begin : g_single
         logic unused_sel;
         assign unused_sel = strobe_n_i ^ sep_strobe_i;
         assign fall_clk_o = ~clk_eff;
      end
   endgenerate
endmodule

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture
   import ddr_in_pkg::*;
(
   input  logic      rise_clk_i,
   input  logic      fall_clk_i,
   input  logic      rst_n_i,
   input  logic      d_i,
   output ddr_pair_t pair_o
);
   logic rise_q;   // sampled at the rising edge
   logic fall_q;   // sampled at the falling edge
   logic fall_al;  // falling sample re-timed to the rising domain
   logic rise_al;  // rising sample held back one period

   always_ff @(posedge rise_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) rise_q <= 1'b0;
      else          rise_q <= d_i;
   end

   always_ff @(posedge fall_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) fall_q <= 1'b0;
      else          fall_q <= d_i;
   end

   always_ff @(posedge rise_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         fall_al <= 1'b0;
         rise_al <= 1'b0;
      end else begin
         fall_al <= fall_q;
         rise_al <= rise_q;
      end
   end

   assign pair_o = '{fall: fall_al, rise: rise_al};
endmodule

// File: rtl/ddr_valid_gen.sv
module ddr_valid_gen (
   input  logic clk_i,
   input  logic rst_n_i,
   output logic valid_o
);
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) valid_o <= 1'b0;
      else          valid_o <= 1'b1;
   end
endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
   import ddr_in_pkg::*;
#(
   parameter int unsigned LANES         = 1,
   parameter bit          SEP_STROBE_EN = 1'b1
) (
   input  logic               clk_i,
   input  logic               strobe_n_i,
   input  logic               rst_n_i,
   input  logic               sep_strobe_i,
   input  logic               invert_i,
   input  logic               bypass_i,
   input  logic [LANES-1:0]   d_i,
   output logic [2*LANES-1:0] data_o,
   output logic               valid_o
);
   localparam int unsigned OUT_W = 2 * LANES;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("ddr_in_capture: LANES must be at least 1");
      end
   endgenerate

   logic rise_clk;
   logic fall_clk;

   ddr_clk_sel #(.SEP_STROBE_EN(SEP_STROBE_EN)) u_clk_sel (
      .clk_i        (clk_i),
      .strobe_n_i   (strobe_n_i),
      .sep_strobe_i (sep_strobe_i),
      .invert_i     (invert_i),
      .rise_clk_o   (rise_clk),
      .fall_clk_o   (fall_clk)
   );

   ddr_valid_gen u_valid (
      .clk_i   (rise_clk),
      .rst_n_i (rst_n_i),
      .valid_o (valid_o)
   );

   logic [OUT_W-1:0] cap_word;
   logic [OUT_W-1:0] byp_word;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      ddr_pair_t pair;
      ddr_lane_capture u_cap (
         .rise_clk_i (rise_clk),
         .fall_clk_i (fall_clk),
         .rst_n_i    (rst_n_i),
         .d_i        (d_i[k]),
         .pair_o     (pair)
      );
      assign cap_word[2*k +: 2] = pair;
      assign byp_word[2*k +: 2] = {1'b0, d_i[k]};
   end

   assign data_o = bypass_i ? byp_word : cap_word;
endmodule

// File: rtl/ddr_in_capture_chk.sv
module ddr_in_capture_chk #(
   parameter int unsigned LANES = 1
) (
   input logic               clk_i,
   input logic               strobe_n_i,
   input logic               rst_n_i,
   input logic               sep_strobe_i,
   input logic               invert_i,
   input logic               bypass_i,
   input logic [LANES-1:0]   d_i,
   input logic [2*LANES-1:0] data_o,
   input logic               valid_o
);
   logic [2*LANES-1:0] byp_exp;
   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         byp_exp[2*k]   = d_i[k];
         byp_exp[2*k+1] = 1'b0;
      end
   end

   // R8
   reset_clear_chk: assert property (@(posedge clk_i)
      !rst_n_i |-> (!valid_o && (bypass_i || data_o == '0)));

   // R9
   valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      valid_o |=> valid_o);

   // R9
   quiet_before_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!valid_o && !bypass_i) |-> data_o == '0);

   // R7
   bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      bypass_i |-> data_o == byp_exp);

   logic unused_in;
   assign unused_in = strobe_n_i ^ sep_strobe_i ^ invert_i;
endmodule

bind ddr_in_capture ddr_in_capture_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_ddr_in_capture.sv
`timescale 1ns/1ps
module tb_ddr_in_capture;
   localparam int NV = 8;
   // {fall, rise}
   localparam logic [1:0] VEC [NV] = '{2'b01, 2'b10, 2'b11, 2'b00,
                                       2'b10, 2'b01, 2'b00, 2'b11};

   logic ph = 1'b0;
   logic inv = 1'b0, sep = 1'b0, freeze = 1'b0, hold_n = 1'b0;
   logic rst_n, bypass, d;
   logic clk_i, strobe_n_i;
   logic [1:0] data_o;
   logic valid_o;
   int n_chk = 0, n_bad = 0;

   always #2 ph = ~ph;  // 250 MHz
   assign clk_i      = ph ^ inv;
   assign strobe_n_i = freeze ? hold_n : (~ph ^ inv);

   ddr_in_capture dut (
      .clk_i(clk_i), .strobe_n_i(strobe_n_i), .rst_n_i(rst_n),
      .sep_strobe_i(sep), .invert_i(inv), .bypass_i(bypass),
      .d_i(d), .data_o(data_o), .valid_o(valid_o)
   );

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic s, input logic i, input logic frz);
      rst_n = 1'b0; bypass = 1'b0; d = 1'b0;
      sep = s; inv = i; freeze = frz;
      @(posedge ph); #1;
      chk("R8 reset clears", {valid_o, data_o}, 3'b000);
      @(negedge ph); #1 rst_n = 1'b1;
      #0.5 chk("R9 valid low before edge", {2'b00, valid_o}, 3'b000);
      @(posedge ph); #1;
      chk("R9 valid after first edge", {valid_o, data_o}, 3'b100);
   endtask

   // fall_dead: odd bit expected to stay 0 (frozen separate strobe)
   task automatic run_stream(input string req, input logic fall_dead);
      logic [1:0] e;
      for (int i = 0; i <= NV; i++) begin
         @(negedge ph); #1 d = (i < NV) ? VEC[i][0] : 1'b0;
         @(posedge ph); #1 d = (i < NV) ? VEC[i][1] : 1'b0;
         if (i > 0) begin
            e = VEC[i-1];
            if (fall_dead) e[1] = 1'b0;
            chk(req, {valid_o, data_o}, {1'b1, e});
         end
      end
   endtask

   initial begin
      // R1 R2 R3 with single clock, then R6 inverted, then R5 separate strobe
      do_reset(1'b0, 1'b0, 1'b0); run_stream("R1 R2 R3 single clock", 1'b0);
      do_reset(1'b0, 1'b1, 1'b0); run_stream("R6 single clock inverted", 1'b0);
      do_reset(1'b1, 1'b0, 1'b0); run_stream("R5 separate strobe", 1'b0);
      do_reset(1'b1, 1'b1, 1'b0); run_stream("R5 R6 separate strobe inverted", 1'b0);
      // R4: frozen strobe_n has no effect in single-clock mode
      do_reset(1'b0, 1'b0, 1'b1); run_stream("R4 strobe_n ignored", 1'b0);
      // R5: frozen strobe_n freezes odd bits in separate mode
      do_reset(1'b1, 1'b1, 1'b1); run_stream("R5 frozen strobe", 1'b1);
      // R7 bypass passes raw pin
      do_reset(1'b0, 1'b0, 1'b0);
      bypass = 1'b1;
      d = 1'b1; #0.3 chk("R7 bypass high", {1'b0, data_o}, 3'b001);
      d = 1'b0; #0.3 chk("R7 bypass low", {1'b0, data_o}, 3'b000);
      d = 1'b1; #0.3 chk("R7 bypass high again", {1'b0, data_o}, 3'b001);
      bypass = 1'b0;
      // R8 asynchronous reset mid-stream
      @(negedge ph); #1 d = 1'b1;
      @(posedge ph); #1 d = 1'b1;
      @(posedge ph); #1 chk("R3 pair before reset", {valid_o, data_o}, 3'b111);
      #0.5 rst_n = 1'b0;
      #0.2 chk("R8 async clear", {valid_o, data_o}, 3'b000);
      #3 rst_n = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule